// File: doc/BRIEF.md
# SMBus Indexed Block Target

This block is the target side of an SMBus link. It runs on a fast system clock and oversamples the SCL and SDA lines. Each line passes through a two-stage synchronizer and a short glitch filter. From the cleaned lines the block detects START, repeated START and STOP conditions and matches a 7-bit device address (default 0x6E, so 0xDC selects a write and 0xDD a read). SDA is driven open-drain: the block only ever pulls the line low, through `sda_oe`.

Every transfer is an indexed block transfer.

- **Write:** the host sends a start index, then a byte count, then that many data bytes. The data bytes land in consecutive registers.
- **Read:** the host sends the start index under the write address, issues a repeated START and re-addresses for reading. The target first returns a byte count taken from its own programmable count register, then returns data from consecutive registers. The host acknowledges each byte and NACKs the last one.

The register array itself sits outside the block, behind a byte-wide port with an address, write data, a write strobe and combinational read data. The count register is held inside the block, at a fixed index of the same register space.

Top module: `smb_blk_target`

## Requirements
- R1: An address byte whose upper seven bits equal the device address (0x6E) with bit 0 = 0 is ACKed. Any other address is not ACKed, and SDA stays undriven with no register written until the next START.
- R2: In a block write (address+W, index N, count X, then X data bytes), the target ACKs every byte. Data byte k is written through the port to register N+k as a single-cycle strobe.
- R3: Data bytes that arrive after the X counted bytes are not ACKed and are discarded. With X = 0, the first data byte is already refused.
- R4: After an index phase, a repeated START followed by address+R (0xDD) is ACKed. The target then returns the count byte, followed by register contents starting at index N, one index further per byte.
- R5: The count register sits at index 6 and resets to 7. A block write to index 6 loads it without strobing the port. The count byte returned in a read equals its current value, and a read of index 6 also returns it.
- R6: Indices at or above the number of registers (8) read as 0x00, and writes to them produce no strobe.
- R7: A read address that does not come directly, by repeated START, after an index phase is not ACKed.
- R8: After the host NACKs a read byte, the target releases SDA and drives nothing further until the next START. A STOP always returns the target to idle.
- R9: `sda_oe` changes only while SCL is low.
- R10: Pulses on SCL or SDA shorter than three system clocks are ignored. They create no clock edge, no START and no STOP.
- R11: During and right after reset, `sda_oe` and `reg_we` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SMBus clock line |
| sda_i | input | 1 | Sampled SMBus data line |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain) |
| reg_addr | output | AW = $clog2(NUM_REGS) | Register index for read and write |
| reg_wdata | output | 8 | Write data to the register array |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Combinational read data for `reg_addr` |

## Verification
The bench sweeps every start index from 0 to 9 with a two-byte block write followed by a full block read. This walks writes across the count register and past the end of the array.

- A design that strobed the port for the count index, or for indices at or above 8, would corrupt the bench's register copy.
- A design that sent data before the count byte, or took the count from the wrong place, would return a shifted read stream.

Further targeted sequences cover a surplus byte after the count, a zero count, a read address with no index phase before it, a host NACK in the middle of a read followed by extra SCL pulses, and two-clock glitches on both lines in the middle of a byte. A design without a working filter would see a false START or STOP and drop the write. A design that kept driving after the NACK would pull the line low during the extra clocks.

// File: rtl/smb_tgt_pkg.sv
package smb_tgt_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_IDX,
      ST_CNT,
      ST_WDAT,
      ST_ACK,
      ST_TX,
      ST_TX_ACK,
      ST_SKIP
   } tgt_state_e;

   localparam logic [7:0] BYTE_ZERO = 8'h00;

endpackage

// File: rtl/smb_glitch_filt.sv
module smb_glitch_filt #(
   parameter int SYNC_LEN = 2,
   parameter int FILT_LEN = 3,
   parameter bit IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (SYNC_LEN < 2) begin : g_sync_chk
      $error("SYNC_LEN must be at least 2");
   end
   if (FILT_LEN < 2) begin : g_filt_chk
      $error("FILT_LEN must be at least 2");
   end

   logic [SYNC_LEN-1:0] sync_q;
   logic [FILT_LEN-1:0] hist_q;
   logic                out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= {SYNC_LEN{IDLE_VAL}};
         hist_q <= {FILT_LEN{IDLE_VAL}};
         out_q  <= IDLE_VAL;
      end else begin
         sync_q <= {sync_q[SYNC_LEN-2:0], din};
         hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
         if (&hist_q)
            out_q <= 1'b1;
         else if (~|hist_q)
            out_q <= 1'b0;
      end
   end

   assign dout = out_q;

   // R10: a filtered transition is always followed by at least one quiet cycle
   p_filt_settle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(out_q) |=> $stable(out_q));

endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);

   logic scl_p_q;
   logic sda_p_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p_q <= 1'b1;
         sda_p_q <= 1'b1;
      end else begin
         scl_p_q <= scl;
         sda_p_q <= sda;
      end
   end

   assign scl_rise = scl & ~scl_p_q;
   assign scl_fall = ~scl & scl_p_q;
   assign start_ev = scl & scl_p_q & sda_p_q & ~sda;
   assign stop_ev  = scl & scl_p_q & ~sda_p_q & sda;

endmodule

// File: rtl/smb_blk_target.sv
module smb_blk_target
   import smb_tgt_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h6E,
   parameter int         NUM_REGS = 8,
   parameter int         CNT_IDX  = 6,
   parameter logic [7:0] CNT_RST  = 8'h07,
   parameter int         SYNC_LEN = 2,
   parameter int         FILT_LEN = 3,
   localparam int        AW       = $clog2(NUM_REGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   output logic          sda_oe,
   output logic [AW-1:0] reg_addr,
   output logic [7:0]    reg_wdata,
   output logic          reg_we,
   input  logic [7:0]    reg_rdata
);

   localparam logic [7:0] NREG8 = 8'(NUM_REGS);
   localparam logic [7:0] CIDX8 = 8'(CNT_IDX);

   if (NUM_REGS < 2 || NUM_REGS > 255) begin : g_nreg_chk
      $error("NUM_REGS must lie in 2..255");
   end
   if (CNT_IDX < 0 || CNT_IDX >= NUM_REGS) begin : g_cidx_chk
      $error("CNT_IDX must address an implemented register");
   end

   // ---------------- line conditioning ----------------
   logic scl_f, sda_f;
   logic scl_rise, scl_fall, start_ev, stop_ev;

   smb_glitch_filt #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN), .IDLE_VAL(1'b1)) u_scl_filt (
      .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_f));

   smb_glitch_filt #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN), .IDLE_VAL(1'b1)) u_sda_filt (
      .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_f));

   smb_bus_events u_events (
      .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev));

   // ---------------- protocol state ----------------
   tgt_state_e    st_q, nxt_q;
   logic [7:0]    sh_q;
   logic [2:0]    bitc_q;
   logic          full_q;
   logic [7:0]    idx_q;
   logic [7:0]    left_q;
   logic [7:0]    cnt_reg_q;
   logic          idxv_q;
   logic          first_q;
   logic [7:0]    tx_q;
   logic          hack_q;
   logic          oe_q;
   logic          we_q;
   logic [AW-1:0] wa_q;
   logic [7:0]    wd_q;

   logic          in_rng, is_cnt, rx_state;
   logic [7:0]    rd_val, ld_val;

   always_comb begin
      in_rng   = idx_q < NREG8;
      is_cnt   = idx_q == CIDX8;
      rx_state = (st_q == ST_ADDR) || (st_q == ST_IDX) ||
                 (st_q == ST_CNT)  || (st_q == ST_WDAT);
      if (!in_rng)
         rd_val = BYTE_ZERO;
      else if (is_cnt)
         rd_val = cnt_reg_q;
      else
         rd_val = reg_rdata;
      ld_val = first_q ? cnt_reg_q : rd_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         nxt_q     <= ST_IDLE;
         sh_q      <= '0;
         bitc_q    <= '0;
         full_q    <= 1'b0;
         idx_q     <= '0;
         left_q    <= '0;
         cnt_reg_q <= CNT_RST;
         idxv_q    <= 1'b0;
         first_q   <= 1'b0;
         tx_q      <= '0;
         hack_q    <= 1'b0;
         oe_q      <= 1'b0;
         we_q      <= 1'b0;
         wa_q      <= '0;
         wd_q      <= '0;
      end else begin
         we_q <= 1'b0;
         if (start_ev) begin
            // a repeated START is only meaningful right after the index ACK
            idxv_q <= (st_q == ST_CNT) && (bitc_q <= 3'd1) && !full_q;
            st_q   <= ST_ADDR;
            bitc_q <= '0;
            full_q <= 1'b0;
            oe_q   <= 1'b0;
         end else if (stop_ev) begin
            st_q   <= ST_IDLE;
            idxv_q <= 1'b0;
            full_q <= 1'b0;
            oe_q   <= 1'b0;
         end else if (rx_state) begin
            if (scl_rise) begin
               sh_q   <= {sh_q[6:0], sda_f};
               bitc_q <= bitc_q + 3'd1;
               if (bitc_q == 3'd7)
                  full_q <= 1'b1;
            end else if (scl_fall && full_q) begin
               full_q <= 1'b0;
               bitc_q <= '0;
               unique case (st_q)
                  ST_ADDR: begin
                     idxv_q <= 1'b0;
                     if (sh_q[7:1] == DEV_ADDR && (!sh_q[0] || idxv_q)) begin
                        oe_q    <= 1'b1;
                        st_q    <= ST_ACK;
                        nxt_q   <= sh_q[0] ? ST_TX : ST_IDX;
                        first_q <= 1'b1;
                     end else begin
                        st_q <= ST_SKIP;
                     end
                  end
                  ST_IDX: begin
                     idx_q <= sh_q;
                     oe_q  <= 1'b1;
                     st_q  <= ST_ACK;
                     nxt_q <= ST_CNT;
                  end
                  ST_CNT: begin
                     left_q <= sh_q;
                     oe_q   <= 1'b1;
                     st_q   <= ST_ACK;
                     nxt_q  <= ST_WDAT;
                  end
                  default: begin
                     if (left_q != 8'd0) begin
                        left_q <= left_q - 8'd1;
                        idx_q  <= idx_q + 8'd1;
                        if (in_rng && is_cnt)
                           cnt_reg_q <= sh_q;
                        else if (in_rng) begin
                           we_q <= 1'b1;
                           wa_q <= idx_q[AW-1:0];
                           wd_q <= sh_q;
                        end
                        oe_q  <= 1'b1;
                        st_q  <= ST_ACK;
                        nxt_q <= ST_WDAT;
                     end else begin
                        st_q <= ST_SKIP;
                     end
                  end
               endcase
            end
         end else begin
            unique case (st_q)
               ST_ACK: begin
                  if (scl_fall) begin
                     bitc_q <= '0;
                     if (nxt_q == ST_TX) begin
                        tx_q    <= ld_val;
                        oe_q    <= ~ld_val[7];
                        first_q <= 1'b0;
                        if (!first_q)
                           idx_q <= idx_q + 8'd1;
                        st_q    <= ST_TX;
                     end else begin
                        oe_q <= 1'b0;
                        st_q <= nxt_q;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bitc_q == 3'd7) begin
                        oe_q <= 1'b0;
                        st_q <= ST_TX_ACK;
                     end else begin
                        bitc_q <= bitc_q + 3'd1;
                        tx_q   <= {tx_q[6:0], 1'b0};
                        oe_q   <= ~tx_q[6];
                     end
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise)
                     hack_q <= ~sda_f;
                  else if (scl_fall) begin
                     bitc_q <= '0;
                     if (hack_q) begin
                        tx_q    <= ld_val;
                        oe_q    <= ~ld_val[7];
                        first_q <= 1'b0;
                        if (!first_q)
                           idx_q <= idx_q + 8'd1;
                        st_q    <= ST_TX;
                     end else begin
                        st_q <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe    = oe_q;
   assign reg_we    = we_q;
   assign reg_wdata = wd_q;
   assign reg_addr  = we_q ? wa_q : idx_q[AW-1:0];

   // R9: the pull-down is only switched on while the filtered clock is low
   p_drive_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> !scl_f);

   // R2: write strobe is a single-cycle pulse
   p_we_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we_q |=> !we_q);

   // R5, R6: strobes never target the count register or missing registers
   p_we_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      we_q |-> (32'(wa_q) < NUM_REGS) && (32'(wa_q) != CNT_IDX));

   // R1: while an acknowledge bit is on the bus, the line is held low
   p_ack_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ACK) && scl_f |-> oe_q);

   // R8: the host owns SDA during its acknowledge slot
   p_host_ack_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_TX_ACK) && scl_f |-> !oe_q);

endmodule

// File: tb/sim_smb_blk_target.sv
module sim_smb_blk_target;

   localparam int NREG = 8;
   localparam int CIDX = 6;
   localparam int Q    = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hscl = 1'b1;
   logic       hsda = 1'b1;
   logic       sda_oe;
   logic [2:0] reg_addr;
   logic [7:0] reg_wdata;
   logic       reg_we;
   logic [7:0] reg_rdata;
   logic       sda_line;

   logic [7:0] mem [NREG];
   logic [7:0] exp_mem [NREG];
   logic [7:0] exp_cnt;
   int checks = 0;
   int errs = 0;
   int bad_edge = 0;
   int oe_cycles = 0;
   int strobes = 0;
   int exp_strobes = 0;
   logic oe_prev = 1'b0;
   logic done = 1'b0;

   always #5 clk = ~clk;

   assign sda_line  = hsda & ~sda_oe;
   assign reg_rdata = mem[reg_addr];

   smb_blk_target u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(hscl), .sda_i(sda_line),
      .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata));

   function automatic logic [7:0] init_val(int i);
      return 8'((i * 41) ^ 90);
   endfunction

   function automatic logic [7:0] wval(int n, int k);
      if (n + k == CIDX) return 8'(1 + (n % 3));
      return 8'((n + 1) * 16 + k + 3);
   endfunction

   function automatic logic [7:0] exp_rd(int i);
      if (i >= NREG) return 8'h00;
      if (i == CIDX) return exp_cnt;
      return exp_mem[i];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) mem[i] <= init_val(i);
      end else begin
         if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            strobes++;
         end
         if (sda_oe !== oe_prev && hscl) bad_edge++;
         if (sda_oe) oe_cycles++;
      end
      oe_prev = sda_oe;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic wait_q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic host_start();
      hsda = 1'b1; wait_q();
      hscl = 1'b1; wait_q();
      hsda = 1'b0; wait_q();
      hscl = 1'b0; wait_q();
   endtask

   task automatic host_stop();
      hsda = 1'b0; wait_q();
      hscl = 1'b1; wait_q();
      hsda = 1'b1; wait_q(); wait_q();
   endtask

   task automatic send_bit(input logic b, input logic glitch);
      hsda = b; wait_q();
      hscl = 1'b1;
      if (glitch) begin
         repeat (3) @(negedge clk);
         hscl = 1'b0; repeat (2) @(negedge clk);
         hscl = 1'b1; repeat (5) @(negedge clk);
         if (b) begin
            hsda = 1'b0; repeat (2) @(negedge clk);
            hsda = 1'b1;
         end else repeat (2) @(negedge clk);
         repeat (8) @(negedge clk);
      end else begin
         wait_q(); wait_q();
      end
      hscl = 1'b0; wait_q();
   endtask

   task automatic get_bit(output logic b);
      hsda = 1'b1; wait_q();
      hscl = 1'b1; wait_q();
      b = sda_line; wait_q();
      hscl = 1'b0; wait_q();
   endtask

   task automatic wbyte(input logic [7:0] v, input logic glitch, output logic ack);
      logic a;
      for (int i = 7; i >= 0; i--) send_bit(v[i], glitch);
      get_bit(a);
      ack = ~a;
   endtask

   task automatic rbyte(output logic [7:0] v, input logic give_ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      send_bit(~give_ack, 1'b0);
   endtask

   task automatic cmp_mem(input string tag);
      repeat (4) @(negedge clk);
      for (int i = 0; i < NREG; i++) chk(tag, {24'd0, mem[i]}, {24'd0, exp_mem[i]});
   endtask

   task automatic blk_write(input int n, input int cnt, input int extra);
      logic a;
      host_start();
      wbyte(8'hDC, 1'b0, a); chk("R1 write address ack", {31'd0, a}, 1);
      wbyte(8'(n), 1'b0, a); chk("R2 index ack", {31'd0, a}, 1);
      wbyte(8'(cnt), 1'b0, a); chk("R2 count ack", {31'd0, a}, 1);
      for (int k = 0; k < cnt; k++) begin
         wbyte(wval(n, k), 1'b0, a);
         chk("R2 data ack", {31'd0, a}, 1);
         if (n + k == CIDX) exp_cnt = wval(n, k);
         else if (n + k < NREG) begin
            exp_mem[n + k] = wval(n, k);
            exp_strobes++;
         end
      end
      for (int e = 0; e < extra; e++) begin
         wbyte(8'(8'hE0 + e), 1'b0, a);
         chk("R3 surplus byte refused", {31'd0, a}, 0);
      end
      host_stop();
      cmp_mem("R2 R6 register contents");
   endtask

   task automatic blk_read(input int n);
      logic       a;
      logic [7:0] d;
      host_start();
      wbyte(8'hDC, 1'b0, a); chk("R1 write address ack", {31'd0, a}, 1);
      wbyte(8'(n), 1'b0, a); chk("R4 index ack", {31'd0, a}, 1);
      host_start();
      wbyte(8'hDD, 1'b0, a); chk("R4 read address ack", {31'd0, a}, 1);
      rbyte(d, exp_cnt != 8'd0);
      chk("R5 count byte", {24'd0, d}, {24'd0, exp_cnt});
      for (int k = 0; k < int'(exp_cnt); k++) begin
         rbyte(d, k != int'(exp_cnt) - 1);
         if (n + k >= NREG) chk("R6 out-of-range reads zero", {24'd0, d}, 0);
         else chk("R4 read data", {24'd0, d}, {24'd0, exp_rd(n + k)});
      end
      host_stop();
      chk("R8 released after read", {31'd0, sda_oe}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++;
         $display("FAIL watchdog R8 actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errs);
         $finish;
      end
   end

   initial begin
      logic       a;
      logic [7:0] d;
      int         oe_before;
      for (int i = 0; i < NREG; i++) exp_mem[i] = init_val(i);
      exp_cnt = 8'h07;
      repeat (5) @(negedge clk);
      chk("R11 sda_oe in reset", {31'd0, sda_oe}, 0);
      chk("R11 reg_we in reset", {31'd0, reg_we}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R11 sda_oe after reset", {31'd0, sda_oe}, 0);
      chk("R11 reg_we after reset", {31'd0, reg_we}, 0);

      // R5: reset count of 7, full read from index 0
      blk_read(0);

      // R1: foreign address is ignored entirely
      oe_before = oe_cycles;
      host_start();
      wbyte(8'hD0, 1'b0, a); chk("R1 foreign address nack", {31'd0, a}, 0);
      wbyte(8'h00, 1'b0, a); wbyte(8'h01, 1'b0, a); wbyte(8'hAA, 1'b0, a);
      host_stop();
      chk("R1 no drive for foreign address", oe_cycles, oe_before);
      cmp_mem("R1 registers untouched");

      // R2 R4 R5 R6: sweep start index over and past the array
      for (int n = 0; n < 10; n++) begin
         blk_write(n, 2, 0);
         blk_read(n);
      end

      // R3: surplus data and zero count
      blk_write(1, 1, 2);
      blk_write(2, 0, 1);

      // R7: read address without index phase
      host_start();
      wbyte(8'hDD, 1'b0, a); chk("R7 bare read nack", {31'd0, a}, 0);
      host_stop();
      host_start();
      wbyte(8'hDC, 1'b0, a); wbyte(8'h00, 1'b0, a);
      host_stop();
      host_start();
      wbyte(8'hDD, 1'b0, a); chk("R7 read after STOP nack", {31'd0, a}, 0);
      host_stop();

      // R8: early NACK from host, then idle clocks
      host_start();
      wbyte(8'hDC, 1'b0, a); wbyte(8'h00, 1'b0, a);
      host_start();
      wbyte(8'hDD, 1'b0, a); chk("R8 read address ack", {31'd0, a}, 1);
      rbyte(d, 1'b1); chk("R8 count", {24'd0, d}, {24'd0, exp_cnt});
      rbyte(d, 1'b0); chk("R8 first byte", {24'd0, d}, {24'd0, exp_rd(0)});
      oe_before = oe_cycles;
      for (int i = 0; i < 9; i++) send_bit(1'b1, 1'b0);
      chk("R8 silent after nack", oe_cycles, oe_before);
      host_stop();
      blk_read(3);

      // R10: glitches on both lines during a write
      host_start();
      wbyte(8'hDC, 1'b1, a); chk("R10 address ack", {31'd0, a}, 1);
      wbyte(8'h00, 1'b1, a); chk("R10 index ack", {31'd0, a}, 1);
      wbyte(8'h01, 1'b1, a); chk("R10 count ack", {31'd0, a}, 1);
      wbyte(8'hB5, 1'b1, a); chk("R10 data ack", {31'd0, a}, 1);
      host_stop();
      exp_mem[0] = 8'hB5;
      exp_strobes++;
      cmp_mem("R10 glitch-free write");

      chk("R6 strobe count", strobes, exp_strobes);
      chk("R9 sda changes with scl high", bad_edge, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
   end

endmodule